// File: doc/BRIEF.md
# Multidrop 9-bit Serial Slave Receiver

This block is one slave node on a shared serial line. A single master talks to several slaves using frames that carry a ninth bit. When the ninth bit is 1, the frame is a selection frame whose low byte names one slave. When it is 0, the frame carries payload for the slave that is currently selected. The node keeps a sleep flag. While the flag is set, payload frames are dropped silently. A selection frame that carries the node's own code clears the flag. A selection frame that carries any other code sets the flag again. As a result, exactly one node on the line passes payload to its host.

Accepted frames appear on a byte output together with their ninth bit. A one-cycle valid strobe and a one-cycle interrupt pulse are raised together when a frame is accepted. The bit rate is fixed by a clocks-per-bit parameter. The node also contains a small 9-bit transmitter, so a selected slave can answer the master, for example to report that a transfer is complete.

Top module: `mp_uart_node`

## Requirements
- R1: A frame is a low start bit, eight data bits with bit 0 sent first, a ninth flag bit, then a high stop bit. Each bit lasts CLKS_PER_BIT clocks and is sampled near its middle. For an accepted frame, `rx_data_o` holds the eight data bits and `rx_bit8_o` holds the ninth bit.
- R2: `rx_valid_o` and `rx_irq_o` are each high for exactly one cycle for every accepted frame, and for nothing else.
- R3: A frame with ninth bit 1 whose data equals `cfg_addr_i` clears `wake_o` to 0 and is delivered with `rx_bit8_o` = 1.
- R4: A frame with ninth bit 1 whose data differs from `cfg_addr_i` sets `wake_o` to 1 and is not delivered.
- R5: A frame with ninth bit 0 that arrives while `wake_o` is 1 is not delivered and raises no interrupt.
- R6: A frame with ninth bit 0 that arrives while `wake_o` is 0 is delivered.
- R7: `wake_o` is 1 after reset. A one-cycle pulse on `cfg_wake_set_i` sets it to 1.
- R8: If the line goes low for fewer than CLKS_PER_BIT/2 clocks and is high again at the start-bit midpoint, no frame is received and no error is reported.
- R9: A stop bit sampled low gives a one-cycle `frame_err_o` pulse. The frame is not delivered and `wake_o` does not change. The receiver looks for the next start bit only after the line has returned high.
- R10: While `cfg_en_i` is 0, the receiver ignores the line. No frame is delivered and `wake_o` does not change.
- R11: The transmitter line `tx_o` is high when idle. A `tx_start_i` pulse while idle sends a low start bit, `tx_data_i` with bit 0 first, `tx_bit8_i`, and a high stop bit, each lasting CLKS_PER_BIT clocks.
- R12: `tx_busy_o` is high from the cycle after a start until the stop bit has been sent completely. A `tx_start_i` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| cfg_en_i | input | 1 | Receiver enable |
| cfg_addr_i | input | DATA_W | Own select code of this node |
| cfg_wake_set_i | input | 1 | Pulse that sets the sleep flag |
| rx_data_o | output | DATA_W | Data of the last accepted frame |
| rx_bit8_o | output | 1 | Ninth bit of the last accepted frame |
| rx_valid_o | output | 1 | One-cycle strobe for an accepted frame |
| rx_irq_o | output | 1 | One-cycle receive interrupt |
| wake_o | output | 1 | Sleep flag (1 means payload frames are filtered) |
| frame_err_o | output | 1 | One-cycle framing error pulse |
| tx_start_i | input | 1 | Request to send one frame |
| tx_data_i | input | DATA_W | Data to send |
| tx_bit8_i | input | 1 | Ninth bit to send |
| tx_o | output | 1 | Serial transmit line |
| tx_busy_o | output | 1 | Transmitter busy |

## Verification
Directed sequences walk the sleep flag through each transition: payload while asleep, its own code, payload while selected, another node's code, and payload again. This separates the filter's four decisions from a receiver that simply accepts everything. A short low glitch and a low stop bit then check that start qualification and framing errors leave both the output and the sleep flag unchanged. A disabled-enable pass shows that the line is fully ignored. A seeded random stream then mixes selection frames, matching and not, with payload and occasional bad stop bits, and compares the result against a bench model of the flag. Finally, two transmitted frames are sampled at bit midpoints, and one of them receives a start request while busy, which must not corrupt it.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

   localparam int unsigned MPU_BYTE_W = 8;

   typedef enum logic [2:0] {
      RX_IDLE  = 3'd0,
      RX_START = 3'd1,
      RX_DATA  = 3'd2,
      RX_STOP  = 3'd3,
      RX_BREAK = 3'd4
   } rx_state_e;

   typedef enum logic {
      TX_IDLE = 1'b0,
      TX_SEND = 1'b1
   } tx_state_e;

endpackage

// File: rtl/mpu_line_sync.sv
module mpu_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign line_o = line_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '1;
            end else if (STAGES == 1) begin
               chain_q[0] <= line_i;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], line_i};
            end
         end
         assign line_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/mpu_rx_deser.sv
module mpu_rx_deser
   import mpu_pkg::*;
#(
   parameter int unsigned CLKS_PER_BIT = 16,
   parameter int unsigned DATA_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              line_i,
   output logic              done_o,
   output logic [DATA_W-1:0] data_o,
   output logic              bit8_o,
   output logic              stop_ok_o
);

   localparam int unsigned CW    = $clog2(CLKS_PER_BIT);
   localparam int unsigned NBITS = DATA_W + 1;
   localparam int unsigned BW    = $clog2(NBITS + 1);
   localparam logic [CW-1:0] LAST_TICK = CW'(CLKS_PER_BIT - 1);
   localparam logic [CW-1:0] MID_TICK  = CW'(CLKS_PER_BIT / 2 - 1);
   localparam logic [BW-1:0] LAST_BIT  = BW'(NBITS - 1);

   rx_state_e        state_q;
   logic [CW-1:0]    tick_q;
   logic [BW-1:0]    bitn_q;
   logic [NBITS-1:0] shift_q;
   logic             done_q;
   logic             stop_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         tick_q  <= '0;
         bitn_q  <= '0;
         shift_q <= '0;
         done_q  <= 1'b0;
         stop_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!en_i) begin
            state_q <= RX_IDLE;
            tick_q  <= '0;
         end else begin
            unique case (state_q)
               RX_IDLE: begin
                  tick_q <= '0;
                  if (!line_i) state_q <= RX_START;
               end
               RX_START: begin
                  if (tick_q == MID_TICK) begin
                     tick_q <= '0;
                     bitn_q <= '0;
                     state_q <= line_i ? RX_IDLE : RX_DATA;
                  end else begin
                     tick_q <= tick_q + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (tick_q == LAST_TICK) begin
                     tick_q  <= '0;
                     shift_q <= {line_i, shift_q[NBITS-1:1]};
                     if (bitn_q == LAST_BIT) begin
                        state_q <= RX_STOP;
                     end else begin
                        bitn_q <= bitn_q + 1'b1;
                     end
                  end else begin
                     tick_q <= tick_q + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (tick_q == LAST_TICK) begin
                     tick_q  <= '0;
                     done_q  <= 1'b1;
                     stop_q  <= line_i;
                     state_q <= line_i ? RX_IDLE : RX_BREAK;
                  end else begin
                     tick_q <= tick_q + 1'b1;
                  end
               end
               RX_BREAK: begin
                  if (line_i) state_q <= RX_IDLE;
               end
               default: state_q <= RX_IDLE;
            endcase
         end
      end
   end

   assign done_o    = done_q;
   assign stop_ok_o = stop_q;
   assign data_o    = shift_q[DATA_W-1:0];
   assign bit8_o    = shift_q[DATA_W];

endmodule

// File: rtl/mpu_wake_filter.sv
module mpu_wake_filter #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              bit8_i,
   input  logic              stop_ok_i,
   input  logic [DATA_W-1:0] own_addr_i,
   input  logic              wake_set_i,
   output logic              wake_o,
   output logic              valid_o,
   output logic              irq_o,
   output logic              ferr_o,
   output logic [DATA_W-1:0] data_o,
   output logic              bit8_o
);

   logic              wake_q;
   logic              valid_q;
   logic              irq_q;
   logic              ferr_q;
   logic [DATA_W-1:0] data_q;
   logic              bit8_q;
   logic              addr_hit;
   logic              accept;

   assign addr_hit = (data_i == own_addr_i);
   assign accept   = done_i && stop_ok_i &&
                     (bit8_i ? addr_hit : !wake_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_q  <= 1'b1;
         valid_q <= 1'b0;
         irq_q   <= 1'b0;
         ferr_q  <= 1'b0;
         data_q  <= '0;
         bit8_q  <= 1'b0;
      end else begin
         valid_q <= accept;
         irq_q   <= accept;
         ferr_q  <= done_i && !stop_ok_i;
         if (accept) begin
            data_q <= data_i;
            bit8_q <= bit8_i;
         end
         if (done_i && stop_ok_i && bit8_i) begin
            wake_q <= !addr_hit;
         end
         if (wake_set_i) begin
            wake_q <= 1'b1;
         end
      end
   end

   assign wake_o  = wake_q;
   assign valid_o = valid_q;
   assign irq_o   = irq_q;
   assign ferr_o  = ferr_q;
   assign data_o  = data_q;
   assign bit8_o  = bit8_q;

endmodule

// File: rtl/mpu_tx_ser.sv
module mpu_tx_ser
   import mpu_pkg::*;
#(
   parameter int unsigned CLKS_PER_BIT = 16,
   parameter int unsigned DATA_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              bit8_i,
   output logic              tx_o,
   output logic              busy_o
);

   localparam int unsigned FW = DATA_W + 3;
   localparam int unsigned CW = $clog2(CLKS_PER_BIT);
   localparam int unsigned BW = $clog2(FW + 1);
   localparam logic [CW-1:0] LAST_TICK = CW'(CLKS_PER_BIT - 1);
   localparam logic [BW-1:0] LAST_BIT  = BW'(FW - 1);

   tx_state_e     state_q;
   logic [FW-1:0] shift_q;
   logic [CW-1:0] tick_q;
   logic [BW-1:0] bitn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TX_IDLE;
         shift_q <= '1;
         tick_q  <= '0;
         bitn_q  <= '0;
      end else begin
         unique case (state_q)
            TX_IDLE: begin
               if (start_i) begin
                  shift_q <= {1'b1, bit8_i, data_i, 1'b0};
                  tick_q  <= '0;
                  bitn_q  <= '0;
                  state_q <= TX_SEND;
               end
            end
            TX_SEND: begin
               if (tick_q == LAST_TICK) begin
                  tick_q  <= '0;
                  shift_q <= {1'b1, shift_q[FW-1:1]};
                  if (bitn_q == LAST_BIT) begin
                     state_q <= TX_IDLE;
                  end else begin
                     bitn_q <= bitn_q + 1'b1;
                  end
               end else begin
                  tick_q <= tick_q + 1'b1;
               end
            end
            default: state_q <= TX_IDLE;
         endcase
      end
   end

   assign tx_o   = shift_q[0];
   assign busy_o = (state_q == TX_SEND);

endmodule

// File: rtl/mp_uart_node.sv
module mp_uart_node
   import mpu_pkg::*;
#(
   parameter int unsigned CLKS_PER_BIT = 16,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned DATA_W       = MPU_BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_i,
   input  logic              cfg_en_i,
   input  logic [DATA_W-1:0] cfg_addr_i,
   input  logic              cfg_wake_set_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_bit8_o,
   output logic              rx_valid_o,
   output logic              rx_irq_o,
   output logic              wake_o,
   output logic              frame_err_o,
   input  logic              tx_start_i,
   input  logic [DATA_W-1:0] tx_data_i,
   input  logic              tx_bit8_i,
   output logic              tx_o,
   output logic              tx_busy_o
);

   generate
      if (CLKS_PER_BIT < 4) begin : g_bad_cpb
         $error("CLKS_PER_BIT must be at least 4");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 4 or fewer");
      end
   endgenerate

   logic              line_s;
   logic              fr_done;
   logic [DATA_W-1:0] fr_data;
   logic              fr_bit8;
   logic              fr_stop_ok;

   mpu_line_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (rx_i),
      .line_o (line_s)
   );

   mpu_rx_deser #(
      .CLKS_PER_BIT (CLKS_PER_BIT),
      .DATA_W       (DATA_W)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (cfg_en_i),
      .line_i    (line_s),
      .done_o    (fr_done),
      .data_o    (fr_data),
      .bit8_o    (fr_bit8),
      .stop_ok_o (fr_stop_ok)
   );

   mpu_wake_filter #(
      .DATA_W (DATA_W)
   ) u_filt (
      .clk        (clk),
      .rst_n      (rst_n),
      .done_i     (fr_done),
      .data_i     (fr_data),
      .bit8_i     (fr_bit8),
      .stop_ok_i  (fr_stop_ok),
      .own_addr_i (cfg_addr_i),
      .wake_set_i (cfg_wake_set_i),
      .wake_o     (wake_o),
      .valid_o    (rx_valid_o),
      .irq_o      (rx_irq_o),
      .ferr_o     (frame_err_o),
      .data_o     (rx_data_o),
      .bit8_o     (rx_bit8_o)
   );

   mpu_tx_ser #(
      .CLKS_PER_BIT (CLKS_PER_BIT),
      .DATA_W       (DATA_W)
   ) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (tx_start_i),
      .data_i  (tx_data_i),
      .bit8_i  (tx_bit8_i),
      .tx_o    (tx_o),
      .busy_o  (tx_busy_o)
   );

endmodule

// File: rtl/mp_uart_node_chk.sv
module mp_uart_node_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_en_i,
   input logic [DATA_W-1:0] cfg_addr_i,
   input logic [DATA_W-1:0] rx_data_o,
   input logic              rx_bit8_o,
   input logic              rx_valid_o,
   input logic              rx_irq_o,
   input logic              wake_o,
   input logic              frame_err_o,
   input logic              tx_o,
   input logic              tx_busy_o
);

   assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o);

   assert_irq_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq_o |=> !rx_irq_o);

   assert_wake_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wake_o) |-> (rx_valid_o && rx_bit8_o && rx_data_o == cfg_addr_i));

   assert_asleep_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_o && !rx_bit8_o) |-> !$past(wake_o));

   assert_ferr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |-> (!rx_valid_o && $stable(wake_o)));

   assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en_i && !$past(cfg_en_i)) |-> !rx_valid_o);

   assert_tx_idle_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy_o |-> tx_o);

   assert_tx_start_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy_o) |-> !tx_o);

endmodule

bind mp_uart_node mp_uart_node_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_en_i    (cfg_en_i),
   .cfg_addr_i  (cfg_addr_i),
   .rx_data_o   (rx_data_o),
   .rx_bit8_o   (rx_bit8_o),
   .rx_valid_o  (rx_valid_o),
   .rx_irq_o    (rx_irq_o),
   .wake_o      (wake_o),
   .frame_err_o (frame_err_o),
   .tx_o        (tx_o),
   .tx_busy_o   (tx_busy_o)
);

// File: tb/mp_uart_node_bench.sv
module mp_uart_node_bench;

   localparam int CPB  = 16;
   localparam int HALF = CPB / 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_i = 1'b1;
   logic       cfg_en_i = 1'b0;
   logic [7:0] cfg_addr_i = 8'h5A;
   logic       cfg_wake_set_i = 1'b0;
   logic [7:0] rx_data_o;
   logic       rx_bit8_o;
   logic       rx_valid_o;
   logic       rx_irq_o;
   logic       wake_o;
   logic       frame_err_o;
   logic       tx_start_i = 1'b0;
   logic [7:0] tx_data_i = 8'h00;
   logic       tx_bit8_i = 1'b0;
   logic       tx_o;
   logic       tx_busy_o;

   int nchk = 0;
   int nfail = 0;
   int vcount = 0;
   int icount = 0;
   int fcount = 0;
   int irq_mis = 0;
   logic [7:0] last_data = 8'h00;
   logic       last_b8 = 1'b0;
   logic       exp_wake = 1'b1;
   logic       timed_out = 1'b0;

   always #10 clk = ~clk;

   mp_uart_node #(
      .CLKS_PER_BIT (CPB),
      .SYNC_STAGES  (2),
      .DATA_W       (8)
   ) u_mp_uart_node (
      .clk            (clk),
      .rst_n          (rst_n),
      .rx_i           (rx_i),
      .cfg_en_i       (cfg_en_i),
      .cfg_addr_i     (cfg_addr_i),
      .cfg_wake_set_i (cfg_wake_set_i),
      .rx_data_o      (rx_data_o),
      .rx_bit8_o      (rx_bit8_o),
      .rx_valid_o     (rx_valid_o),
      .rx_irq_o       (rx_irq_o),
      .wake_o         (wake_o),
      .frame_err_o    (frame_err_o),
      .tx_start_i     (tx_start_i),
      .tx_data_i      (tx_data_i),
      .tx_bit8_i      (tx_bit8_i),
      .tx_o           (tx_o),
      .tx_busy_o      (tx_busy_o)
   );

   always @(negedge clk) begin
      if (rx_valid_o) begin
         vcount++;
         last_data = rx_data_o;
         last_b8   = rx_bit8_o;
      end
      if (rx_irq_o) icount++;
      if (rx_irq_o != rx_valid_o) irq_mis++;
      if (frame_err_o) fcount++;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit model_deliver(input logic [7:0] d, input logic b8,
                                        input logic stp, input logic wk,
                                        input logic [7:0] own);
      if (!stp) return 1'b0;
      if (b8) return (d == own);
      return !wk;
   endfunction

   function automatic logic model_wake(input logic [7:0] d, input logic b8,
                                       input logic stp, input logic wk,
                                       input logic [7:0] own);
      if (!stp || !b8) return wk;
      return (d != own);
   endfunction

   task automatic send_frame(input logic [7:0] d, input logic b8, input logic stp);
      logic [10:0] bits;
      bits = {stp, b8, d, 1'b0};
      for (int i = 0; i < 11; i++) begin
         rx_i = bits[i];
         repeat (CPB) @(negedge clk);
      end
      rx_i = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic run_frame(input logic [7:0] d, input logic b8, input logic stp,
                            input string req);
      int v0, f0;
      bit dlv;
      v0 = vcount;
      f0 = fcount;
      dlv = cfg_en_i && model_deliver(d, b8, stp, exp_wake, cfg_addr_i);
      if (cfg_en_i) exp_wake = model_wake(d, b8, stp, exp_wake, cfg_addr_i);
      send_frame(d, b8, stp);
      chk(vcount - v0 == int'(dlv), req, "delivered count", vcount - v0, int'(dlv));
      if (dlv) begin
         chk(last_data == d && last_b8 == b8, req, "data/bit8",
             {last_b8, last_data}, {b8, d});
      end
      chk(wake_o == exp_wake, req, "wake flag", wake_o, exp_wake);
      chk(fcount - f0 == int'(cfg_en_i && !stp), req, "framing errors",
          fcount - f0, int'(cfg_en_i && !stp));
   endtask

   task automatic tx_frame(input logic [7:0] d, input logic b8, input bit poke);
      logic [10:0] exp_bits;
      logic [10:0] got;
      exp_bits = {1'b1, b8, d, 1'b0};
      tx_data_i  = d;
      tx_bit8_i  = b8;
      tx_start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tx_start_i = 1'b0;
      repeat (HALF - 1) @(negedge clk);
      got[0] = tx_o;
      chk(tx_busy_o == 1'b1, "R12", "busy during frame", tx_busy_o, 1);
      for (int i = 1; i < 11; i++) begin
         repeat (CPB) @(negedge clk);
         got[i] = tx_o;
         if (poke && i == 3) begin
            tx_data_i  = ~d;
            tx_bit8_i  = ~b8;
            tx_start_i = 1'b1;
            @(negedge clk);
            tx_start_i = 1'b0;
            repeat (CPB - 1) @(negedge clk);
            i++;
            got[i] = tx_o;
         end
      end
      chk(got == exp_bits, poke ? "R12" : "R11", "tx bits", got, exp_bits);
      repeat (CPB) @(negedge clk);
      chk(tx_busy_o == 1'b0 && tx_o == 1'b1, "R12", "idle after stop",
          {tx_busy_o, tx_o}, 2'b01);
   endtask

   task automatic main_seq();
      int v0, f0;
      logic [7:0] d;
      logic b8, stp;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7: reset state
      chk(wake_o == 1'b1, "R7", "wake after reset", wake_o, 1);
      chk(rx_valid_o == 1'b0 && rx_irq_o == 1'b0 && frame_err_o == 1'b0, "R2",
          "strobes after reset", {rx_valid_o, rx_irq_o, frame_err_o}, 0);
      chk(tx_o == 1'b1 && tx_busy_o == 1'b0, "R11", "tx idle after reset",
          {tx_o, tx_busy_o}, 2'b10);

      cfg_en_i = 1'b1;
      repeat (4) @(negedge clk);
      run_frame(8'h3C, 1'b0, 1'b1, "R5");
      run_frame(8'h5A, 1'b1, 1'b1, "R3");
      run_frame(8'hC3, 1'b0, 1'b1, "R6");
      run_frame(8'h01, 1'b0, 1'b1, "R1");
      run_frame(8'h11, 1'b1, 1'b1, "R4");
      run_frame(8'h99, 1'b0, 1'b1, "R5");

      // R7: wake-set pulse
      run_frame(8'h5A, 1'b1, 1'b1, "R3");
      cfg_wake_set_i = 1'b1;
      @(negedge clk);
      cfg_wake_set_i = 1'b0;
      @(negedge clk);
      exp_wake = 1'b1;
      chk(wake_o == 1'b1, "R7", "wake after set pulse", wake_o, 1);
      run_frame(8'h77, 1'b0, 1'b1, "R7");

      // R8: short glitch
      v0 = vcount;
      f0 = fcount;
      rx_i = 1'b0;
      repeat (3) @(negedge clk);
      rx_i = 1'b1;
      repeat (3 * CPB) @(negedge clk);
      chk(vcount == v0 && fcount == f0, "R8", "glitch events",
          (vcount - v0) + (fcount - f0), 0);
      run_frame(8'h5A, 1'b1, 1'b1, "R8");

      // R9: bad stop bit while selected, then recovery
      run_frame(8'hE7, 1'b0, 1'b0, "R9");
      run_frame(8'h42, 1'b0, 1'b1, "R9");
      run_frame(8'h5A, 1'b1, 1'b0, "R9");

      // R10: disabled receiver
      run_frame(8'h13, 1'b1, 1'b1, "R4");
      cfg_en_i = 1'b0;
      run_frame(8'h5A, 1'b1, 1'b1, "R10");
      cfg_en_i = 1'b1;
      repeat (4) @(negedge clk);
      run_frame(8'h5A, 1'b1, 1'b1, "R10");

      // Random mix (R1, R3..R6, R9)
      for (int n = 0; n < 60; n++) begin
         b8  = ($urandom % 3) == 0;
         d   = 8'($urandom);
         if (b8 && ($urandom % 2) == 0) d = cfg_addr_i;
         stp = ($urandom % 10) != 0;
         run_frame(d, b8, stp, "R1");
      end
      chk(icount == vcount && irq_mis == 0, "R2", "irq pulses vs valid",
          icount, vcount);

      // R11 and R12: transmitter
      tx_frame(8'hA5, 1'b1, 1'b0);
      tx_frame(8'h3E, 1'b0, 1'b1);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      fork
         main_seq();
         begin
            repeat (190000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      if (timed_out) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule